// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small processor core and decides, at each instruction boundary, whether the core should divert into an interrupt handler and, if so, where to. Each of `NSRC` request lines is either event-type (a pulse latches a sticky pending flag) or level-type (it requests only while held high and keeps no flag); the split is fixed by the `LVL_MASK` parameter. A request counts only when its own enable bit and the global enable bit are both 1. Among counted requests the lowest index wins, because its vector sits lowest in the table. Slot 0 belongs to reset, so source `i` vectors to `base + 2*(i+1)`.

The core reports retirement with `instr_done`. It pulses `sei_pulse`, `cli_pulse` or `reti_pulse` in the same cycle as the `instr_done` of the matching instruction. In the cycle where `irq_take` is high the core must push its program counter and jump to `irq_vec`; `irq_idx` names the source. `boot_sel` moves the table base from 0 to `BOOT_BASE`. The core owns the entry latency, sleep wake-up and the completion of multi-cycle instructions, since it only raises `instr_done` at a true boundary.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `gie` is 0, every bit of `flags` is 0, all individual enables are 0 and `irq_take` is 0.
- R2: `irq_take` is 1 only in a cycle with `instr_done`=1 and `gie`=1, where some source is both enabled and pending.
- R3: When several enabled sources are pending, `irq_idx` in the take cycle is the lowest pending index.
- R4: In the take cycle `irq_vec` equals base + 2*(`irq_idx`+1), where base is 0 when `boot_sel`=0 and `BOOT_BASE` when `boot_sel`=1.
- R5: The cycle after a take, `gie` reads 0.
- R6: A 1 on an event-type line sets its bit in `flags` on the next edge, whether or not it is enabled, and the bit stays 1 until cleared.
- R7: Writing with `flag_wr`=1 clears each event flag whose `flag_wdata` bit is 1; bits written 0 keep their value; a new event in the same cycle as the clear keeps the flag at 1.
- R8: A take clears the flag of the winning event-type source on the next edge and leaves other flags unchanged.
- R9: Level-type sources never show a bit in `flags`; they request only in cycles where the line is 1, so a level that drops before being enabled is never served.
- R10: A cycle carrying `reti_pulse` never takes; `gie` is 1 the next cycle, and the following boundary may take.
- R11: A cycle carrying `sei_pulse` never takes; the following boundary may take.
- R12: A cycle carrying `cli_pulse` never takes, even with a request arriving in that cycle, and `gie` is 0 the next cycle.
- R13: A cycle with `instr_done`=0 never takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NSRC | Request lines, one per source |
| instr_done | input | 1 | An instruction retires this cycle |
| sei_pulse | input | 1 | Retiring instruction sets global enable |
| cli_pulse | input | 1 | Retiring instruction clears global enable |
| reti_pulse | input | 1 | Retiring instruction returns from a handler |
| en_wr | input | 1 | Load the individual enable register |
| en_wdata | input | NSRC | New individual enable bits |
| flag_wr | input | 1 | Write-one-to-clear strobe for flags |
| flag_wdata | input | NSRC | Bits whose flags are to be cleared |
| boot_sel | input | 1 | Vector table base select |
| gie | output | 1 | Global enable state |
| flags | output | NSRC | Pending event flags |
| irq_take | output | 1 | Divert to a handler at this boundary |
| irq_idx | output | IDXW | Winning source index |
| irq_vec | output | ADDR_W | Handler vector address |

## Verification
The bench aims at the boundary rules: a controller that samples the next-state enable instead of the held one would take an interrupt in the very cycle of an enable or a return and skip the guaranteed instruction, while one that ignores a same-cycle disable would divert right after it. It races a fresh event against a software clear and against a take, where a wrong precedence drops a request silently. It also drops a level request before enabling it, which a design that latched levels would still serve, and checks both table bases, where an off-by-one slot would land the core on the reset vector or a neighbour's handler.

// File: rtl/pic_pkg.sv
package pic_pkg;

  // Control pulses that arrive with a retiring instruction.
  typedef struct packed {
    logic sei;
    logic cli;
    logic reti;
  } gie_cmd_t;

  function automatic logic cmd_any(gie_cmd_t c);
    return c.sei | c.cli | c.reti;
  endfunction

endpackage

// File: rtl/pic_gie_ctl.sv
module pic_gie_ctl
  import pic_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  gie_cmd_t cmd,
  input  logic     take,
  output logic     gie_q
);

  logic gie_d;
  logic gie_ce;

  always_comb begin
    gie_ce = take | cmd_any(cmd);
    gie_d  = gie_q;
    if (cmd.sei | cmd.reti) gie_d = 1'b1;
    if (cmd.cli)            gie_d = 1'b0;
    if (take)               gie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gie_q <= 1'b0;
    else if (gie_ce) gie_q <= gie_d;
  end

  // R5: entry drops the global enable
  a_r5_take_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie_q);
  // R10: return restores the global enable
  a_r10_reti_sets_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.reti && !cmd.cli && !take) |=> gie_q);
  // R12: disable lands on the next edge
  a_r12_cli_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.cli |=> !gie_q);

endmodule

// File: rtl/pic_src_bank.sv
module pic_src_bank #(
  parameter int          NSRC     = 8,
  parameter logic [NSRC-1:0] LVL_MASK = '0,
  localparam int         IDXW     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic            en_wr,
  input  logic [NSRC-1:0] en_wdata,
  input  logic            clr_wr,
  input  logic [NSRC-1:0] clr_wdata,
  input  logic            take,
  input  logic [IDXW-1:0] take_idx,
  output logic [NSRC-1:0] flag_q,
  output logic [NSRC-1:0] req
);

  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_wdata;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (LVL_MASK[i]) begin : g_lvl
      assign flag_q[i] = 1'b0;
      assign raw[i]    = src[i];
    end else begin : g_evt
      logic f_q;
      logic f_d;
      logic f_ce;
      logic hit;

      always_comb begin
        hit  = take && (take_idx == IDXW'(i));
        f_ce = src[i] | (clr_wr & clr_wdata[i]) | hit;
        f_d  = src[i];   // a fresh event outranks any clear
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    f_q <= 1'b0;
        else if (f_ce) f_q <= f_d;
      end

      assign flag_q[i] = f_q;
      assign raw[i]    = f_q;

      // R6: an event always latches
      a_r6_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
        src[i] |=> f_q);
      // R7 / R8: a clear with no competing event empties the flag
      a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (((clr_wr && clr_wdata[i]) || hit) && !src[i]) |=> !f_q);
    end
  end

  assign req = raw & en_q;

endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
  parameter int  NSRC = 8,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  output logic            valid,
  output logic [IDXW-1:0] idx
);

  logic [NSRC-1:0] below;

  always_comb begin
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) idx = IDXW'(i);
    end
    valid = |req;
    below = (NSRC'(1) << idx) - NSRC'(1);
  end

  // R3: winner is a live request with nothing pending beneath it
  a_r3_winner_live: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> req[idx]);
  a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($countones(req & below) == 0));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int              NSRC      = 8,
  parameter logic [NSRC-1:0] LVL_MASK  = 8'hC0,
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hE000,
  localparam int             IDXW      = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_req,
  input  logic              instr_done,
  input  logic              sei_pulse,
  input  logic              cli_pulse,
  input  logic              reti_pulse,
  input  logic              en_wr,
  input  logic [NSRC-1:0]   en_wdata,
  input  logic              flag_wr,
  input  logic [NSRC-1:0]   flag_wdata,
  input  logic              boot_sel,
  output logic              gie,
  output logic [NSRC-1:0]   flags,
  output logic              irq_take,
  output logic [IDXW-1:0]   irq_idx,
  output logic [ADDR_W-1:0] irq_vec
);

  gie_cmd_t        cmd;
  logic [NSRC-1:0] req;
  logic            pick_valid;
  logic [IDXW-1:0] pick_idx;
  logic [IDXW:0]   slot;
  logic [ADDR_W-1:0] base;

  assign cmd = '{sei: sei_pulse, cli: cli_pulse, reti: reti_pulse};

  pic_src_bank #(.NSRC(NSRC), .LVL_MASK(LVL_MASK)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (src_req),
    .en_wr     (en_wr),
    .en_wdata  (en_wdata),
    .clr_wr    (flag_wr),
    .clr_wdata (flag_wdata),
    .take      (irq_take),
    .take_idx  (pick_idx),
    .flag_q    (flags),
    .req       (req)
  );

  pic_prio_pick #(.NSRC(NSRC)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .valid (pick_valid),
    .idx   (pick_idx)
  );

  pic_gie_ctl u_gie (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (cmd),
    .take  (irq_take),
    .gie_q (gie)
  );

  // Decision uses the held enable, so an enabling instruction never
  // lets a handler preempt the instruction right after it.
  always_comb begin
    irq_take = instr_done & gie & ~cmd_any(cmd) & pick_valid;
    base     = boot_sel ? BOOT_BASE : '0;
    slot     = {1'b0, pick_idx} + (IDXW+1)'(1);
    irq_vec  = base + ADDR_W'({slot, 1'b0});
    irq_idx  = pick_idx;
  end

  // R2 / R13: takes only at an enabled boundary
  a_r2_take_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (gie && instr_done && (req != '0)));
  // R10 / R11 / R12: boundaries of enable, disable and return never divert
  a_r12_cmd_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (sei_pulse || cli_pulse || reti_pulse) |-> !irq_take);
  // R9: level sources show no flag
  a_r9_no_level_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & LVL_MASK) == '0);

endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;

  localparam int          NSRC = 8;
  localparam int          IDXW = 3;
  localparam int          AW   = 16;
  localparam logic [7:0]  LVL  = 8'hC0;
  localparam logic [15:0] BOOT = 16'hE000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src_req = '0, en_wdata = '0, flag_wdata = '0;
  logic instr_done = 0, sei_pulse = 0, cli_pulse = 0, reti_pulse = 0;
  logic en_wr = 0, flag_wr = 0, boot_sel = 0;
  logic gie, irq_take;
  logic [NSRC-1:0] flags;
  logic [IDXW-1:0] irq_idx;
  logic [AW-1:0]   irq_vec;

  int checks = 0, fails = 0;

  // model state
  logic [NSRC-1:0] m_flag, m_en;
  logic            m_gie;

  always #10 clk = ~clk;

  prio_irq_ctrl #(.NSRC(NSRC), .LVL_MASK(LVL), .ADDR_W(AW), .BOOT_BASE(BOOT)) u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .instr_done(instr_done),
    .sei_pulse(sei_pulse), .cli_pulse(cli_pulse), .reti_pulse(reti_pulse),
    .en_wr(en_wr), .en_wdata(en_wdata), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .boot_sel(boot_sel), .gie(gie), .flags(flags), .irq_take(irq_take),
    .irq_idx(irq_idx), .irq_vec(irq_vec)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [NSRC-1:0] mreq();
    return ((m_flag & ~LVL) | (src_req & LVL)) & m_en;
  endfunction

  function automatic int lowest(input logic [NSRC-1:0] r);
    for (int i = NSRC - 1; i >= 0; i--) if (r[i]) lowest = i;
    if (r == '0) lowest = 0;
  endfunction

  function automatic logic mtake();
    return instr_done && m_gie && !sei_pulse && !cli_pulse && !reti_pulse && (mreq() != '0);
  endfunction

  function automatic logic [AW-1:0] mvec(input int w);
    return (boot_sel ? BOOT : 16'h0) + AW'(2 * (w + 1));
  endfunction

  task automatic idle_inputs();
    src_req = '0; instr_done = 0; sei_pulse = 0; cli_pulse = 0; reti_pulse = 0;
    en_wr = 0; flag_wr = 0; en_wdata = '0; flag_wdata = '0;
  endtask

  // One cycle: inputs already set after a falling edge.
  task automatic tick();
    logic t;
    int w;
    #1;
    t = mtake();
    w = lowest(mreq());
    chk(irq_take, t, "R2 take");
    if (t) begin
      chk(irq_idx, w, "R3 index");
      chk(irq_vec, mvec(w), "R4 vector");
    end
    @(posedge clk);
    m_flag = (m_flag & ~(flag_wr ? flag_wdata : '0) & ~(t ? NSRC'(1) << w : '0)) | (src_req & ~LVL);
    m_flag = m_flag & ~LVL;
    if (t) m_gie = 0;
    else if (cli_pulse) m_gie = 0;
    else if (sei_pulse || reti_pulse) m_gie = 1;
    if (en_wr) m_en = en_wdata;
    @(negedge clk);
    chk(gie, m_gie, "R5 gie");
    chk(flags, m_flag, "R6 flags");
    idle_inputs();
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_flag = '0; m_en = '0; m_gie = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(gie, 0, "R1 gie");
    chk(flags, 0, "R1 flags");
    chk(irq_take, 0, "R1 take");
    @(negedge clk);

    // R6: disabled event latches and holds
    src_req = 8'h08; tick();
    chk(flags, 8'h08, "R6 latch");
    tick(); tick();
    chk(flags, 8'h08, "R6 hold");
    // R7: zero write, clear racing event, plain clear
    flag_wr = 1; flag_wdata = 8'h00; tick();
    chk(flags, 8'h08, "R7 zero write");
    flag_wr = 1; flag_wdata = 8'h08; src_req = 8'h08; tick();
    chk(flags, 8'h08, "R7 event beats clear");
    flag_wr = 1; flag_wdata = 8'h08; tick();
    chk(flags, 8'h00, "R7 cleared");
    // R9: level line leaves no flag
    src_req = 8'h40; tick();
    chk(flags, 8'h00, "R9 no flag");
    // R11: enable all, two events pending, sei boundary does not take
    en_wr = 1; en_wdata = 8'hFF; src_req = 8'h24; tick();
    instr_done = 1; sei_pulse = 1; #1;
    chk(irq_take, 0, "R11 sei boundary");
    tick();
    instr_done = 1; #1;
    chk(irq_take, 1, "R11 next boundary");
    chk(irq_idx, 2, "R3 lowest");
    chk(irq_vec, 16'h0006, "R4 base zero");
    tick();
    chk(gie, 0, "R5 cleared");
    chk(flags, 8'h20, "R8 winner cleared");
    // R13: no boundary, no take
    instr_done = 1; sei_pulse = 1; tick();
    #1; chk(irq_take, 0, "R13 no boundary");
    tick();
    boot_sel = 1; instr_done = 1; #1;
    chk(irq_vec, 16'hE00C, "R4 boot base");
    tick();
    // R10: return boundary never takes, next may
    src_req = 8'h10; tick();
    instr_done = 1; reti_pulse = 1; #1;
    chk(irq_take, 0, "R10 reti boundary");
    tick();
    chk(gie, 1, "R10 gie set");
    instr_done = 1; #1;
    chk(irq_idx, 4, "R10 served after one");
    chk(irq_take, 1, "R10 take");
    tick();
    // R12: disable with same-cycle request
    instr_done = 1; sei_pulse = 1; tick();
    instr_done = 1; cli_pulse = 1; src_req = 8'h80; #1;
    chk(irq_take, 0, "R12 cli same cycle");
    tick();
    chk(gie, 0, "R12 gie off");
    // R9: level dropped before enable is lost
    src_req = 8'h80; tick(); tick();
    instr_done = 1; sei_pulse = 1; tick();
    instr_done = 1; #1;
    chk(irq_take, 0, "R9 lost level");
    tick();
    src_req = 8'h80; instr_done = 1; #1;
    chk(irq_take, 1, "R9 level served");
    chk(irq_idx, 7, "R9 level index");
    tick();
    boot_sel = 0;

    // constrained random phase
    for (int n = 0; n < 3000; n++) begin
      src_req = NSRC'($urandom & $urandom & $urandom);
      instr_done = ($urandom % 10) < 6;
      if (instr_done) begin
        case ($urandom % 20)
          0, 1:    sei_pulse = 1;
          2:       cli_pulse = 1;
          3, 4, 5: reti_pulse = 1;
          default: ;
        endcase
      end
      en_wr = ($urandom % 20) == 0;
      en_wdata = NSRC'($urandom);
      flag_wr = ($urandom % 15) == 0;
      flag_wdata = NSRC'($urandom);
      if (($urandom % 50) == 0) boot_sel = ~boot_sel;
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule